// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller with Vector Fetch

This block gathers a set of interrupt sources for a single processor and drives one active-low request line to the core. Each source has a priority, a trigger kind (level or rising edge), an enable and a handler address, all held in registers on a simple read/write strobe bus. When the core takes the interrupt it reads the vector register. That read returns the handler address of the winning source, makes that source the one in service and lowers the request line. A write to the end-of-service register finishes the handler.

Servicing nests. A source whose priority is strictly above the level in service raises the request line again. Taking it saves the interrupted source number and level in an eight-entry hardware stack. Each end-of-service write restores the context below it. Source 0 is reserved and never requests. A vector read that finds nothing eligible returns a programmable spurious value and leaves the state as it was.

Bus reads return data in the cycle after the read strobe. The request line is registered. It follows a change of controller state one cycle after the clock edge that made the change.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the request line `irq_n` is high, and three reads all return 0: the enable mask (read at address 0x42), the pending mask (read at address 0x44), and every source mode register.
- R2: A pending source requests only while it is enabled. Writing a mask to 0x42 sets enable bits and writing a mask to 0x43 clears them (bit n is source n). A pending source that is disabled leaves `irq_n` high.
- R3: A read of address 0x40 with an eligible source returns the handler address of that source's register (address 0x20+n). The winner is the highest priority, and among equal priorities the lowest source number. Mode register n is at address 0x00+n, with the priority in bits [2:0] and the edge-trigger select in bit 4.
- R4: A successful vector read lowers the request line when no source of strictly higher priority than the taken one is pending and enabled.
- R5: A vector read that takes an edge-triggered source clears that source's pending bit. A level-triggered source stays pending while its input stays high.
- R6: While a source is in service, only an enabled pending source of strictly greater priority drives `irq_n` low. Equal or lower priority does not.
- R7: A write to address 0x41 ends the current service and restores the interrupted source and level. Sources blocked by the inner level then become eligible again.
- R8: With no eligible source, a vector read returns the spurious value (register 0x45) and changes neither the source in service nor the stack.
- R9: An edge-triggered source latches pending on a rising input. The latch is cleared by a vector read of that source or by writing its bit to 0x44. A level source's pending bit follows its input.
- R10: Source 0 is never pending and never requests, whatever its input and enable.
- R11: Eight sources of priorities 0 to 7 can nest one inside the next. They unwind in reverse order through end-of-service writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Interrupt source inputs, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt request to the core |

## Verification
The assertions check several properties on every cycle. A low request line always follows an enabled pending source. A taken nested source always raises the level in service. A spurious vector read never disturbs the context. The stack never pushes when full or pops when empty. Only the bench's scenarios can show that the right handler address comes back for each priority pattern and tie. They also show the full eight-deep nest and its unwind, blocked sources becoming eligible after an end-of-service write, and edge latches cleared by a vector read or a software clear.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned SLOT_W        = 5;
  localparam logic [7:0]  A_VEC_BASE    = 8'h20;
  localparam logic [7:0]  A_IVEC        = 8'h40;
  localparam logic [7:0]  A_EOI         = 8'h41;
  localparam logic [7:0]  A_ENSET       = 8'h42;
  localparam logic [7:0]  A_ENCLR       = 8'h43;
  localparam logic [7:0]  A_PCLR        = 8'h44;
  localparam logic [7:0]  A_SPUR        = 8'h45;
  localparam int unsigned MODE_EDGE_BIT = 4;

  typedef enum logic [1:0] {RG_MODE, RG_VEC, RG_CTRL, RG_NONE} region_e;
endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NSRC-1:0]               src_in,
  input  logic                          mode_we,
  input  logic [IDX_W-1:0]              mode_idx,
  input  logic [PRIO_W-1:0]             mode_prio,
  input  logic                          mode_edge,
  input  logic [NSRC-1:0]               en_set,
  input  logic [NSRC-1:0]               en_clr,
  input  logic [NSRC-1:0]               pend_clr,
  output logic [NSRC-1:0]               pend,
  output logic [NSRC-1:0]               en,
  output logic [NSRC-1:0]               edge_mode,
  output logic [NSRC-1:0][PRIO_W-1:0]   prio
);
  logic [NSRC-1:0] src_q, src_d, edge_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      src_d     <= '0;
      edge_p    <= '0;
      en        <= '0;
      edge_mode <= '0;
      prio      <= '0;
    end else begin
      src_q  <= src_in;
      src_d  <= src_q;
      // a rising edge in the same cycle as a clear wins, so no edge is lost
      edge_p <= ((edge_p & ~pend_clr) | (src_q & ~src_d)) & edge_mode;
      en     <= (en | en_set) & ~en_clr;
      if (mode_we) begin
        prio[mode_idx]      <= mode_prio;
        edge_mode[mode_idx] <= mode_edge;
      end
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_pend
    if (g == 0) begin : g_rsvd
      assign pend[g] = 1'b0;
    end else begin : g_live
      assign pend[g] = edge_mode[g] ? edge_p[g] : src_q[g];
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             req,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  input  logic                        cur_valid,
  input  logic [PRIO_W-1:0]           cur_lvl,
  output logic                        any,
  output logic [IDX_W-1:0]            win_idx,
  output logic [PRIO_W-1:0]           win_prio
);
  logic [NSRC-1:0] elig;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = req[g] && (!cur_valid || (prio[g] > cur_lvl));
  end

  // ascending scan with strict compare: lowest number wins a tie
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!any || (prio[i] > win_prio))) begin
        any      = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/nic_ctx_stack.sv
module nic_ctx_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] top_ptr;

  assign top_ptr  = cnt - CNT_W'(1);
  assign top_data = mem[top_ptr[PTR_W-1:0]];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[cnt[PTR_W-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (push) cnt <= cnt + CNT_W'(1);
    else if (pop)  cnt <= cnt - CNT_W'(1);
  end

  a_r11_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r7_no_pop_empty:  assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
  a_r7_single_op:     assert property (@(posedge clk) disable iff (rst) !(push && pop));
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned PRIO_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEPTH     = 8,
  parameter logic [31:0] SPUR_INIT = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n
);
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned CTX_W = IDX_W + PRIO_W;

  // ---------------- address decode ----------------
  region_e          region;
  logic [IDX_W-1:0] slot;
  logic             slot_ok;

  assign slot    = bus_addr[IDX_W-1:0];
  assign slot_ok = ({27'd0, bus_addr[SLOT_W-1:0]} < NSRC);

  always_comb begin
    if (bus_addr[7:SLOT_W] == 3'd0 && slot_ok)      region = RG_MODE;
    else if (bus_addr[7:SLOT_W] == A_VEC_BASE[7:SLOT_W] && slot_ok) region = RG_VEC;
    else if (bus_addr[7:SLOT_W] == A_IVEC[7:SLOT_W]) region = RG_CTRL;
    else                                             region = RG_NONE;
  end

  // ---------------- source bank ----------------
  logic [NSRC-1:0]             pend, en, edge_mode, en_set, en_clr, pend_clr, take_clr;
  logic [NSRC-1:0][PRIO_W-1:0] prio;
  logic                        any, take, vec_rd, eoi;
  logic [IDX_W-1:0]            win_idx;
  logic [PRIO_W-1:0]           win_prio;

  assign vec_rd   = bus_rd && (bus_addr == A_IVEC);
  assign take     = vec_rd && any;
  assign en_set   = (bus_wr && bus_addr == A_ENSET) ? bus_wdata[NSRC-1:0] : '0;
  assign en_clr   = (bus_wr && bus_addr == A_ENCLR) ? bus_wdata[NSRC-1:0] : '0;
  assign take_clr = take ? (NSRC'(1) << win_idx) : '0;
  assign pend_clr = take_clr | ((bus_wr && bus_addr == A_PCLR) ? bus_wdata[NSRC-1:0] : '0);

  nic_src_bank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .src_in    (src_in),
    .mode_we   (bus_wr && region == RG_MODE),
    .mode_idx  (slot),
    .mode_prio (bus_wdata[PRIO_W-1:0]),
    .mode_edge (bus_wdata[MODE_EDGE_BIT]),
    .en_set    (en_set),
    .en_clr    (en_clr),
    .pend_clr  (pend_clr),
    .pend      (pend),
    .en        (en),
    .edge_mode (edge_mode),
    .prio      (prio)
  );

  // ---------------- context in service ----------------
  logic              cur_valid;
  logic [IDX_W-1:0]  cur_src;
  logic [PRIO_W-1:0] cur_lvl;
  logic [CTX_W-1:0]  stk_top;
  logic              stk_empty, stk_full;

  nic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) i_arb (
    .req       (pend & en),
    .prio      (prio),
    .cur_valid (cur_valid),
    .cur_lvl   (cur_lvl),
    .any       (any),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  assign eoi = bus_wr && (bus_addr == A_EOI) && cur_valid;

  nic_ctx_stack #(.DEPTH(DEPTH), .W(CTX_W)) i_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (take && cur_valid),
    .pop       (eoi && !stk_empty),
    .push_data ({cur_src, cur_lvl}),
    .top_data  (stk_top),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      cur_src   <= '0;
      cur_lvl   <= '0;
    end else if (take) begin
      cur_valid <= 1'b1;
      cur_src   <= win_idx;
      cur_lvl   <= win_prio;
    end else if (eoi) begin
      if (stk_empty) cur_valid <= 1'b0;
      else {cur_src, cur_lvl} <= stk_top;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !any;
  end

  // ---------------- handler address memory and read path ----------------
  logic [DATA_W-1:0] vmem [NSRC];
  logic [DATA_W-1:0] vec_q, reg_q, rd_word, spur_q;
  logic [IDX_W-1:0]  vaddr;
  logic              rsel_mem;

  assign vaddr = vec_rd ? win_idx : slot;

  always_ff @(posedge clk) begin
    if (bus_wr && region == RG_VEC) vmem[slot] <= bus_wdata;
    vec_q <= vmem[vaddr];
  end

  always_ff @(posedge clk) begin
    if (rst) spur_q <= DATA_W'(SPUR_INIT);
    else if (bus_wr && bus_addr == A_SPUR) spur_q <= bus_wdata;
  end

  always_comb begin
    rd_word = '0;
    if (region == RG_MODE) begin
      rd_word[PRIO_W-1:0]    = prio[slot];
      rd_word[MODE_EDGE_BIT] = edge_mode[slot];
    end else if (bus_addr == A_IVEC || bus_addr == A_SPUR) begin
      rd_word = spur_q;
    end else if (bus_addr == A_ENSET) begin
      rd_word[NSRC-1:0] = en;
    end else if (bus_addr == A_PCLR) begin
      rd_word[NSRC-1:0] = pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_mem <= 1'b0;
      reg_q    <= '0;
    end else if (bus_rd) begin
      rsel_mem <= take || (region == RG_VEC);
      reg_q    <= rd_word;
    end
  end

  assign bus_rdata = rsel_mem ? vec_q : reg_q;

  // ---------------- assertions ----------------
  a_r2_req_needs_enabled: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(|(pend & en)));
  a_r3_winner_pending: assert property (@(posedge clk) disable iff (rst)
    any |-> (pend[win_idx] && en[win_idx]));
  a_r6_nest_raises_level: assert property (@(posedge clk) disable iff (rst)
    (take && cur_valid) |=> (cur_lvl > $past(cur_lvl)));
  a_r8_spurious_keeps_ctx: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !any) |=> ($stable(cur_valid) && $stable(cur_src) && $stable(cur_lvl)));
  a_r10_src0_never_wins: assert property (@(posedge clk) disable iff (rst)
    any |-> (win_idx != '0));
endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  localparam logic [31:0] SPUR = 32'hDEAD_0BAD;

  always #2 clk = ~clk;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  function automatic logic [31:0] vec_of(int i);
    return 32'hA000_0000 | (i << 8) | (i * 3);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    rd(8'h42, d); chk("R1 enable mask", d, 32'd0);
    rd(8'h44, d); chk("R1 pending mask", d, 32'd0);
    rd(8'h05, d); chk("R1 mode reg", d, 32'd0);

    wr(8'h45, SPUR);
    for (int i = 1; i < 32; i++) wr(8'h20 + 8'(i), vec_of(i));
    for (int i = 1; i < 32; i++) begin
      rd(8'h20 + 8'(i), d); chk("R3 handler readback", d, vec_of(i));
    end
    wr(8'h07, 32'h13);
    rd(8'h07, d); chk("R3 mode readback", d, 32'h13);

    // R10: source 0 reserved
    src_in[0] = 1'b1; wr(8'h42, 32'h1); settle();
    rd(8'h44, d); chk("R10 pending bit0", d, 32'd0);
    chk("R10 irq_n", {31'd0, irq_n}, 32'd1);
    wr(8'h43, 32'h1); src_in[0] = 1'b0;

    // R2: enable gating
    wr(8'h03, 32'h2); src_in[3] = 1'b1; settle();
    chk("R2 disabled irq_n", {31'd0, irq_n}, 32'd1);
    rd(8'h44, d); chk("R9 level pending follows input", d, 32'h8);
    wr(8'h42, 32'h8); settle();
    chk("R2 enabled irq_n", {31'd0, irq_n}, 32'd0);
    rd(8'h42, d); chk("R2 enable mask", d, 32'h8);
    wr(8'h43, 32'h8); settle();
    chk("R2 cleared irq_n", {31'd0, irq_n}, 32'd1);
    src_in[3] = 1'b0;

    // R3/R4: priority patterns with ties
    for (int k = 0; k < 4; k++) begin
      int best, bp;
      logic [31:0] act;
      act = '0; best = 0; bp = -1;
      for (int i = 1; i < 32; i++) begin
        int p;
        p = (i * (2 * k + 3) + k) % 8;
        wr(8'(i), 32'(p));
        if (((i * 7 + k) % 3) != 0) begin
          act[i] = 1'b1;
          if (p > bp) begin bp = p; best = i; end
        end
      end
      wr(8'h42, 32'hFFFF_FFFE);
      src_in = act; settle();
      chk("R3 pattern irq_n", {31'd0, irq_n}, 32'd0);
      rd(8'h40, d); chk("R3 pattern winner vector", d, vec_of(best));
      settle();
      chk("R4 irq_n after take", {31'd0, irq_n}, 32'd1);
      src_in = '0; wr(8'h41, 32'd0); settle();
      chk("R7 idle after eoi", {31'd0, irq_n}, 32'd1);
      wr(8'h43, 32'hFFFF_FFFF);
    end

    // R8: spurious reads
    rd(8'h40, d); chk("R8 idle spurious", d, SPUR);
    wr(8'h05, 32'h6); wr(8'h06, 32'h2); wr(8'h42, 32'h60);
    src_in[5] = 1'b1; settle();
    rd(8'h40, d); chk("R3 take src5", d, vec_of(5));
    src_in[6] = 1'b1; settle();
    chk("R6 lower blocked", {31'd0, irq_n}, 32'd1);
    rd(8'h40, d); chk("R8 blocked spurious", d, SPUR);
    src_in[5] = 1'b0; wr(8'h41, 32'd0); settle();
    chk("R8 context intact", {31'd0, irq_n}, 32'd0);
    rd(8'h40, d); chk("R8 next take src6", d, vec_of(6));
    src_in[6] = 1'b0; wr(8'h41, 32'd0); settle();
    rd(8'h40, d); chk("R8 stack empty spurious", d, SPUR);
    wr(8'h43, 32'hFFFF_FFFF);

    // R5/R9: edge sources
    wr(8'h09, 32'h14); wr(8'h42, 32'h200);
    @(negedge clk); src_in[9] = 1'b1; @(negedge clk); src_in[9] = 1'b0;
    settle();
    rd(8'h44, d); chk("R9 edge latched", d, 32'h200);
    chk("R9 edge irq_n", {31'd0, irq_n}, 32'd0);
    rd(8'h40, d); chk("R5 edge take vector", d, vec_of(9));
    rd(8'h44, d); chk("R5 edge cleared by take", d, 32'd0);
    settle();
    chk("R5 irq_n after edge take", {31'd0, irq_n}, 32'd1);
    wr(8'h41, 32'd0);
    @(negedge clk); src_in[9] = 1'b1; @(negedge clk); src_in[9] = 1'b0;
    settle();
    wr(8'h44, 32'h200); settle();
    rd(8'h44, d); chk("R9 software clear", d, 32'd0);
    chk("R9 irq_n after clear", {31'd0, irq_n}, 32'd1);
    src_in[9] = 1'b1; settle();
    rd(8'h40, d); chk("R9 held edge take", d, vec_of(9));
    wr(8'h41, 32'd0); settle();
    rd(8'h44, d); chk("R9 held edge once", d, 32'd0);
    chk("R9 held edge irq_n", {31'd0, irq_n}, 32'd1);
    src_in[9] = 1'b0;
    wr(8'h0C, 32'h1); wr(8'h42, 32'h1000);
    src_in[12] = 1'b1; settle();
    rd(8'h40, d); chk("R5 level take", d, vec_of(12));
    rd(8'h44, d); chk("R5 level stays pending", d, 32'h1000);
    wr(8'h41, 32'd0); settle();
    chk("R5 level re-requests", {31'd0, irq_n}, 32'd0);
    src_in[12] = 1'b0; settle();
    chk("R5 level released", {31'd0, irq_n}, 32'd1);
    wr(8'h43, 32'hFFFF_FFFF);

    // R6/R7/R11: eight-deep nesting and unwind
    for (int j = 1; j <= 8; j++) wr(8'(j), 32'(j - 1));
    wr(8'h0A, 32'h7); wr(8'h0B, 32'h3);
    wr(8'h42, 32'h0000_0DFE);
    for (int j = 1; j <= 8; j++) begin
      src_in[j] = 1'b1; settle();
      chk("R11 nest request", {31'd0, irq_n}, 32'd0);
      rd(8'h40, d); chk("R11 nest vector", d, vec_of(j));
      settle();
      chk("R6 nest quiet", {31'd0, irq_n}, 32'd1);
    end
    src_in[10] = 1'b1; src_in[11] = 1'b1; settle();
    chk("R6 equal priority blocked", {31'd0, irq_n}, 32'd1);
    src_in[8] = 1'b0; wr(8'h41, 32'd0); settle();
    chk("R7 restored level 6", {31'd0, irq_n}, 32'd0);
    rd(8'h40, d); chk("R7 src10 after restore", d, vec_of(10));
    src_in[10] = 1'b0; wr(8'h41, 32'd0); settle();
    chk("R7 back to src7", {31'd0, irq_n}, 32'd1);
    for (int j = 7; j >= 5; j--) begin
      src_in[j] = 1'b0; wr(8'h41, 32'd0); settle();
      chk("R7 unwind blocked", {31'd0, irq_n}, 32'd1);
    end
    src_in[4] = 1'b0; wr(8'h41, 32'd0); settle();
    chk("R7 level 2 unblocks src11", {31'd0, irq_n}, 32'd0);
    rd(8'h40, d); chk("R7 src11 vector", d, vec_of(11));
    src_in[11] = 1'b0; wr(8'h41, 32'd0); settle();
    chk("R7 back to src3", {31'd0, irq_n}, 32'd1);
    for (int j = 3; j >= 1; j--) begin
      src_in[j] = 1'b0; wr(8'h41, 32'd0); settle();
      chk("R11 unwind tail", {31'd0, irq_n}, 32'd1);
    end
    rd(8'h40, d); chk("R11 fully unwound spurious", d, SPUR);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule